// File: doc/BRIEF.md
# Clock Synthesizer Calibration Sequencer

This block is the control sequencer that brings a PLL-based clock generator out of reset and through VCO calibration. Three sources hold the machine in reset: the power-on reset, an active-low power-down pin, and a software reset bit held in a register. The pin is asynchronous and passes through a two-flop synchronizer. The software bit is already in the clock domain. The sequence starts when every reset source has returned high.

Leaving reset through power-up or through the pin asks the register bank to reload its default settings. Leaving reset through the software bit asks for no reload, so the frequency plan already in the registers is kept. A stabilization timer then runs. Calibration is started only when that timer has expired and the supply-good input is high, whichever of the two happens last.

While calibration runs, and until the PLL reports lock, the outputs selected by the auto-mute mask are held muted. A calibration that does not finish within a programmable number of cycles leaves the block in a sticky failed state, with the mutes kept on. The next reset clears that state.

Top module: `cal_sequencer`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `reloadReq`, `calStart`, `inNormal` and `calFail` are 0 and `muteEn` is all zeros.
- R2: After power-on reset is released, with `pdnPin` and `swResetBit` both high, `reloadReq` is high for exactly one cycle, three cycles after the release.
- R3: After `pdnPin` is held low and then returns high, `reloadReq` is high for exactly one cycle, three cycles after the rising input. It is never high at any other time.
- R4: When `swResetBit` is written to 0 and then back to 1, `reloadReq` stays 0. The sequence restarts one cycle after the bit returns to 1.
- R5: Take cycle S as the first cycle after the machine leaves reset. `calStart` is a single-cycle pulse in cycle max(S+RESET_CYCLES, G)+1, where G is the last cycle in which `supplyGood` was sampled low.
- R6: From the `calStart` cycle until lock is reported, `muteEn` equals `autoMuteMask`. Outside that window, and outside the failed state, `muteEn` is all zeros.
- R7: After `calDone`, the machine stays muted with `inNormal` low until `pllLock` is sampled high. In the next cycle `inNormal` is 1 and `muteEn` is all zeros.
- R8: If `calDone` has not arrived by the time `calTimeout` cycles have passed since `calStart`, `calFail` rises one cycle later. It stays set with `muteEn` equal to `autoMuteMask`, and no new `calStart` is issued, until a reset source is asserted. That reset clears it.
- R9: A reset source asserted in any state, including during stabilization or calibration, returns the machine to reset. From the next cycle `muteEn` is zero. After release, the full stabilization time is run again.
- R10: `inNormal` is high only while both `pdnPin` and `swResetBit` are high. It falls no later than one cycle after the bit falls, and no later than three cycles after the pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| pdnPin | input | 1 | Asynchronous active-low power-down pin |
| swResetBit | input | 1 | Software reset register bit; 0 holds reset, rests at 1 |
| supplyGood | input | 1 | Internal supplies are at their correct level |
| pllLock | input | 1 | PLL lock indication |
| calDone | input | 1 | Calibration engine reports completion |
| calTimeout | input | TIMEOUT_WIDTH | Maximum calibration length in cycles |
| autoMuteMask | input | NUM_CHANNELS | Per-channel auto-mute enable |
| reloadReq | output | 1 | One-cycle request to reload the default settings |
| calStart | output | 1 | One-cycle calibration start strobe |
| muteEn | output | NUM_CHANNELS | Per-channel mute enable |
| inNormal | output | 1 | Normal operation status |
| calFail | output | 1 | Sticky calibration timeout flag |

## Verification
The hardest cases to reach are an abort in the middle of calibration or stabilization, and a timeout. In both, an internal counter must be part-way through or at its limit when a reset source or the end of the window arrives. The bench reaches these by counting cycles exactly from each release, then dropping the software bit a few cycles into calibration or stabilization. It also holds `calDone` back until the timeout counter has run out. After each abort, the cycle of the next `calStart` shows whether the timer was cleared. A table of scenarios varies the reset source, the mute mask and how late supply-good rises relative to the timer.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_STAB   = 3'd1,
    ST_CAL    = 3'd2,
    ST_LOCK   = 3'd3,
    ST_NORMAL = 3'd4,
    ST_FAIL   = 3'd5
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic stabRun;
    logic calRun;
    logic muteWindow;
  } dpCtrl_t;

  // datapath -> control conditions
  typedef struct packed {
    logic pinLow;
    logic timerExpired;
    logic calTimedOut;
  } dpStat_t;

endpackage

// File: rtl/cal_seq_dp.sv
module cal_seq_dp
  import cal_seq_pkg::*;
#(
  parameter int NUM_CHANNELS  = 4,
  parameter int RESET_CYCLES  = 16,
  parameter int TIMEOUT_WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pdnPin,
  input  logic [TIMEOUT_WIDTH-1:0] calTimeout,
  input  logic [NUM_CHANNELS-1:0]  autoMuteMask,
  input  dpCtrl_t                  ctrl,
  output dpStat_t                  stat,
  output logic [NUM_CHANNELS-1:0]  muteEn
);

  localparam int TW = $clog2(RESET_CYCLES + 1);
  localparam logic [TW-1:0] TIMER_MAX = TW'(RESET_CYCLES);
  localparam logic [TIMEOUT_WIDTH-1:0] CAL_MAX = '1;

  logic [1:0]               pdnSync;
  logic [TW-1:0]            stabCnt;
  logic [TIMEOUT_WIDTH-1:0] calCnt;

  // two-flop synchronizer for the asynchronous pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdnSync <= '0;
    else       pdnSync <= {pdnSync[0], pdnPin};
  end

  // stabilization timer, cleared whenever the machine is not stabilizing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     stabCnt <= '0;
    else if (!ctrl.stabRun)        stabCnt <= '0;
    else if (stabCnt != TIMER_MAX) stabCnt <= stabCnt + 1'b1;
  end

  // calibration watchdog counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 calCnt <= '0;
    else if (!ctrl.calRun)     calCnt <= '0;
    else if (calCnt != CAL_MAX) calCnt <= calCnt + 1'b1;
  end

  always_comb begin
    stat.pinLow       = !pdnSync[1];
    stat.timerExpired = (stabCnt == TIMER_MAX);
    stat.calTimedOut  = (calCnt == calTimeout);
  end

  // per-channel mute gating
  for (genvar ch = 0; ch < NUM_CHANNELS; ch++) begin : gMute
    assign muteEn[ch] = ctrl.muteWindow & autoMuteMask[ch];
  end

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    swResetBit,
  input  logic    supplyGood,
  input  logic    pllLock,
  input  logic    calDone,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    reloadReq,
  output logic    calStart,
  output logic    calFail,
  output logic    inNormal
);

  seqState_t state, nextState;
  logic holdReset;
  logic reloadPending;
  logic leaveReset;

  assign holdReset  = stat.pinLow || !swResetBit;
  assign leaveReset = (state == ST_RESET) && !holdReset;

  always_comb begin
    nextState = state;
    if (holdReset) begin
      nextState = ST_RESET;
    end else begin
      unique case (state)
        ST_RESET:  nextState = ST_STAB;
        ST_STAB:   if (stat.timerExpired && supplyGood) nextState = ST_CAL;
        ST_CAL: begin
          if (calDone)               nextState = ST_LOCK;
          else if (stat.calTimedOut) nextState = ST_FAIL;
        end
        ST_LOCK:   if (pllLock) nextState = ST_NORMAL;
        ST_NORMAL: nextState = ST_NORMAL;
        ST_FAIL:   nextState = ST_FAIL;
        default:   nextState = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nextState;
  end

  // power-up and pin resets request a reload of defaults; software reset does not
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            reloadPending <= 1'b1;
    else if (stat.pinLow) reloadPending <= 1'b1;
    else if (leaveReset)  reloadPending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadReq <= 1'b0;
      calStart  <= 1'b0;
      calFail   <= 1'b0;
    end else begin
      reloadReq <= leaveReset && reloadPending;
      calStart  <= (state == ST_STAB) && (nextState == ST_CAL);
      if (nextState == ST_RESET)
        calFail <= 1'b0;
      else if ((state == ST_CAL) && (nextState == ST_FAIL))
        calFail <= 1'b1;
    end
  end

  always_comb begin
    ctrl.stabRun    = (state == ST_STAB);
    ctrl.calRun     = (state == ST_CAL);
    ctrl.muteWindow = (state == ST_CAL) || (state == ST_LOCK) || (state == ST_FAIL);
    inNormal        = (state == ST_NORMAL);
  end

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int NUM_CHANNELS  = 4,
  parameter int RESET_CYCLES  = 16,
  parameter int TIMEOUT_WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pdnPin,
  input  logic                     swResetBit,
  input  logic                     supplyGood,
  input  logic                     pllLock,
  input  logic                     calDone,
  input  logic [TIMEOUT_WIDTH-1:0] calTimeout,
  input  logic [NUM_CHANNELS-1:0]  autoMuteMask,
  output logic                     reloadReq,
  output logic                     calStart,
  output logic [NUM_CHANNELS-1:0]  muteEn,
  output logic                     inNormal,
  output logic                     calFail
);

  dpCtrl_t ctrlBus;
  dpStat_t statBus;

  cal_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .swResetBit (swResetBit),
    .supplyGood (supplyGood),
    .pllLock    (pllLock),
    .calDone    (calDone),
    .stat       (statBus),
    .ctrl       (ctrlBus),
    .reloadReq  (reloadReq),
    .calStart   (calStart),
    .calFail    (calFail),
    .inNormal   (inNormal)
  );

  cal_seq_dp #(
    .NUM_CHANNELS  (NUM_CHANNELS),
    .RESET_CYCLES  (RESET_CYCLES),
    .TIMEOUT_WIDTH (TIMEOUT_WIDTH)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .pdnPin       (pdnPin),
    .calTimeout   (calTimeout),
    .autoMuteMask (autoMuteMask),
    .ctrl         (ctrlBus),
    .stat         (statBus),
    .muteEn       (muteEn)
  );

endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker #(
  parameter int NUM_CHANNELS = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    pdnPin,
  input logic                    swResetBit,
  input logic                    supplyGood,
  input logic                    pllLock,
  input logic [NUM_CHANNELS-1:0] autoMuteMask,
  input logic                    reloadReq,
  input logic                    calStart,
  input logic [NUM_CHANNELS-1:0] muteEn,
  input logic                    inNormal,
  input logic                    calFail
);

  a_r2_reload_single: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |=> !reloadReq);

  a_r5_start_single: assert property (@(posedge clk) disable iff (!rstN)
    calStart |=> !calStart);

  a_r5_start_needs_supply: assert property (@(posedge clk) disable iff (!rstN)
    calStart |-> $past(supplyGood));

  a_r6_mute_within_mask: assert property (@(posedge clk) disable iff (!rstN)
    (muteEn & ~autoMuteMask) == '0);

  a_r7_normal_after_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inNormal) |-> $past(pllLock));

  a_r8_fail_cleared_by_reset: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calFail) |-> (!$past(swResetBit) || !$past(pdnPin, 3)));

  a_r9_abort_unmutes: assert property (@(posedge clk) disable iff (!rstN)
    !swResetBit |=> (muteEn == '0 && !inNormal));

  a_r10_normal_needs_bit: assert property (@(posedge clk) disable iff (!rstN)
    inNormal |-> $past(swResetBit));

endmodule

bind cal_sequencer cal_seq_checker #(.NUM_CHANNELS(NUM_CHANNELS)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .pdnPin       (pdnPin),
  .swResetBit   (swResetBit),
  .supplyGood   (supplyGood),
  .pllLock      (pllLock),
  .autoMuteMask (autoMuteMask),
  .reloadReq    (reloadReq),
  .calStart     (calStart),
  .muteEn       (muteEn),
  .inNormal     (inNormal),
  .calFail      (calFail)
);

// File: tb/sim_cal_sequencer.sv
module sim_cal_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int RC  = 16;
  localparam int TOW = 16;
  localparam int TIMEOUT = 20;

  // scenario vector: {mask[3:0], viaSoftware, supplyDelay[7:0]}
  localparam int NVEC = 5;
  localparam logic [12:0] VEC [NVEC] = '{
    {4'b1010, 1'b0, 8'd0},
    {4'b0111, 1'b1, 8'd0},
    {4'b1111, 1'b1, 8'd40},
    {4'b0001, 1'b0, 8'd30},
    {4'b0000, 1'b1, 8'd5}
  };

  logic clk = 1'b0;
  logic rstN, pdnPin, swResetBit, supplyGood, pllLock, calDone;
  logic [TOW-1:0] calTimeout;
  logic [NCH-1:0] autoMuteMask;
  logic reloadReq, calStart, inNormal, calFail;
  logic [NCH-1:0] muteEn;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_sequencer #(.NUM_CHANNELS(NCH), .RESET_CYCLES(RC), .TIMEOUT_WIDTH(TOW)) u0 (
    .clk(clk), .rstN(rstN), .pdnPin(pdnPin), .swResetBit(swResetBit),
    .supplyGood(supplyGood), .pllLock(pllLock), .calDone(calDone),
    .calTimeout(calTimeout), .autoMuteMask(autoMuteMask),
    .reloadReq(reloadReq), .calStart(calStart), .muteEn(muteEn),
    .inNormal(inNormal), .calFail(calFail)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // release has just happened; walk to the calStart cycle and check each cycle
  task automatic runRelease(input logic [NCH-1:0] mask, input bit expReload,
                            input int stab, input int sgDelay, input string tag);
    int expStart;
    int reloadErr;
    int startErr;
    int muteErr;
    expStart  = ((stab + RC > sgDelay) ? stab + RC : sgDelay) + 1;
    reloadErr = 0; startErr = 0; muteErr = 0;
    supplyGood = (sgDelay == 0);
    for (int k = 1; k <= expStart; k++) begin
      @(negedge clk);
      if (reloadReq !== (expReload && k == stab)) reloadErr++;
      if (calStart !== (k == expStart)) startErr++;
      if (k < expStart && muteEn !== '0) muteErr++;
      if (k == sgDelay) supplyGood = 1'b1;
    end
    check(reloadErr == 0, expReload ? "R3" : "R4", {tag, " reload pulse cycle"},
          reloadErr, 0);
    check(startErr == 0, "R5", {tag, " calStart cycle"}, startErr, 0);
    check(muteErr == 0 && muteEn == mask, "R6", {tag, " mutes at calStart"},
          muteEn, mask);
  endtask

  task automatic finishCal(input logic [NCH-1:0] mask);
    step(3);
    calDone = 1'b1;
    step(1);
    calDone = 1'b0;
    step(3);
    check(muteEn == mask && !inNormal, "R7", "muted while awaiting lock",
          {muteEn, 3'b0, inNormal}, {mask, 4'b0});
    pllLock = 1'b1;
    step(1);
    check(inNormal && muteEn == '0, "R7", "normal and unmuted after lock",
          {muteEn, 3'b0, inNormal}, 1);
  endtask

  task automatic applyReset(input bit viaSw);
    pllLock = 1'b0;
    supplyGood = 1'b0;
    if (viaSw) begin
      swResetBit = 1'b0;
      step(1);
    end else begin
      pdnPin = 1'b0;
      step(3);
    end
    check(!inNormal && muteEn == '0, "R10", "left normal under reset",
          {muteEn, 3'b0, inNormal}, 0);
    step(1);
  endtask

  task automatic releaseReset(input bit viaSw);
    if (viaSw) swResetBit = 1'b1;
    else       pdnPin = 1'b1;
  endtask

  initial begin
    step(100000);
    total++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rstN = 1'b0; pdnPin = 1'b1; swResetBit = 1'b1; supplyGood = 1'b1;
    pllLock = 1'b0; calDone = 1'b0; calTimeout = TOW'(TIMEOUT);
    autoMuteMask = 4'b0110;
    step(2);
    // R1 reset state
    check(!reloadReq && !calStart && !inNormal && !calFail && muteEn == '0,
          "R1", "outputs in reset", {reloadReq, calStart, inNormal, calFail, muteEn}, 0);
    rstN = 1'b1;
    step(1);
    check(!reloadReq && !calStart && !inNormal && !calFail && muteEn == '0,
          "R1", "outputs first cycle after reset", {reloadReq, calStart, inNormal, calFail, muteEn}, 0);
    // power-up path: R2 (two cycles remain of the three)
    begin
      int rl = 0;
      for (int k = 2; k <= 3; k++) begin
        @(negedge clk);
        if (reloadReq !== (k == 3)) rl++;
      end
      check(rl == 0, "R2", "power-up reload pulse", rl, 0);
      step(RC);
      check(calStart == 1'b0, "R5", "no start before timer", calStart, 0);
      step(1);
      check(calStart == 1'b1, "R5", "power-up calStart", calStart, 1);
      finishCal(4'b0110);
    end

    // table of scenarios
    for (int v = 0; v < NVEC; v++) begin
      logic [NCH-1:0] m;
      bit sw;
      int dly;
      m = VEC[v][12:9]; sw = VEC[v][8]; dly = int'(VEC[v][7:0]);
      applyReset(sw);
      autoMuteMask = m;
      releaseReset(sw);
      runRelease(m, !sw, sw ? 1 : 3, dly, sw ? "R4 vec" : "R3 vec");
      finishCal(m);
    end

    // R8 timeout
    autoMuteMask = 4'b1100;
    applyReset(1'b1);
    releaseReset(1'b1);
    runRelease(4'b1100, 1'b0, 1, 0, "R8 setup");
    step(TIMEOUT);
    check(!calFail, "R8", "no fail at timeout limit", calFail, 0);
    step(1);
    check(calFail && muteEn == 4'b1100, "R8", "fail flag and mutes",
          {calFail, muteEn}, {1'b1, 4'b1100});
    begin
      int st = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (calStart || !calFail) st++;
      end
      check(st == 0, "R8", "fail sticky, no restart", st, 0);
    end
    pdnPin = 1'b0;
    step(3);
    check(!calFail && muteEn == '0, "R8", "fail cleared by pin reset",
          {calFail, muteEn}, 0);
    step(1);
    pdnPin = 1'b1;
    runRelease(4'b1100, 1'b1, 3, 0, "R8 recover");
    finishCal(4'b1100);

    // R9 abort during calibration
    autoMuteMask = 4'b1011;
    applyReset(1'b1);
    releaseReset(1'b1);
    runRelease(4'b1011, 1'b0, 1, 0, "R9 setup");
    step(2);
    swResetBit = 1'b0;
    step(1);
    check(muteEn == '0 && !inNormal && !calFail, "R9", "abort mid-calibration",
          {muteEn, inNormal, calFail}, 0);
    step(1);
    swResetBit = 1'b1;
    runRelease(4'b1011, 1'b0, 1, 0, "R9 after cal abort");
    finishCal(4'b1011);

    // R9 abort during stabilization: timer must restart in full
    applyReset(1'b1);
    releaseReset(1'b1);
    supplyGood = 1'b1;
    step(10);
    swResetBit = 1'b0;
    step(2);
    swResetBit = 1'b1;
    runRelease(4'b1011, 1'b0, 1, 0, "R9 after stab abort");
    finishCal(4'b1011);

    // R10: software reset drops normal within one cycle
    swResetBit = 1'b0;
    step(1);
    check(!inNormal, "R10", "normal falls after bit write", inNormal, 0);
    swResetBit = 1'b1;
    step(2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule